// File: doc/BRIEF.md
# Microcoded Sequencer for a Multicycle Load/Store Core

This block is the control half of a multicycle processor. It holds a micro-program counter and two small read-only tables. The first table is a control store of 16-bit encoded microwords. The second table maps each opcode to an entry point. In every cycle the microword at the current micro-address is expanded into the strobes and select codes that drive the datapath. A 2-bit sequencing field in the same microword then picks the next micro-address.

The datapath reports two flags back to the controller: the ALU zero flag and the ALU overflow flag. The zero flag gates the PC load in the branch-equal step. The overflow flag can divert the register-type routine into an exception step before its write-back. An opcode with no routine of its own enters a separate exception step. Each exception step raises a one-cycle entry strobe with a cause code for an external exception-register unit, and then control returns to fetch. The micro-address is brought out so that the routine being run can be observed.

Top module: `ucodeCtrl`

## Requirements
- R1: A synchronous active-high reset forces the micro-address to 0. The outputs then show the fetch microinstruction.
- R2: At micro-address 0 the outputs are as follows: aluOp=00, aluSelA=0 (PC), aluSelB=001 (constant 4), memRead=1 with iorD=0 (PC address), irWrite=1, pcLoad=1 with pcSrc=00. The next micro-address is 1.
- R3: The next micro-address is chosen by a 2-bit field. Code 00 goes to 0, code 01 takes the dispatch-table entry, and code 10 takes the current address plus one. Code 11 also takes the address plus one, unless the overflow flag is set. Micro-address 1 (decode) sets aluSelB=011 and uses code 01.
- R4: The dispatch table maps opcodes to entry points: 0 (register type) to 2, 13 (or-immediate) to 4, 35 (load) to 6, 43 (store) to 9, 4 (branch-equal) to 11 and 2 (jump) to 13. Every other opcode maps to 12. Each routine takes a fixed number of cycles from its entry point back to address 0: register type 2, or-immediate 2, load 3, store 2, branch 1, jump 1, undefined 1.
- R5: aluOp encodes the ALU operation: 00 add, 01 subtract, 10 function code, 11 OR. The register-type execute step uses 10, the or-immediate step uses 11, the branch step uses 01, and the address steps use 00.
- R6: aluSelB encodes the second operand: 000 rt, 001 constant 4, 010 sign-extended immediate, 011 sign-extended immediate shifted left by 2, 100 zero-extended immediate.
- R7: pcSrc encodes the PC source: 00 ALU result, 01 branch target register, 10 jump address. The branch step drives 01 and the jump step drives 10.
- R8: In the branch step (address 11), pcLoad follows the ALU zero flag, cycle by cycle.
- R9: If the overflow flag is high in the register-type execute step (address 2), the next address is 14 and no register write takes place. Otherwise the write-back step (address 3) follows with regWrite=1 and regDst=1. Overflow has no effect in any other step.
- R10: Address 12 asserts excEntry with excCause=10. Address 14 asserts excEntry with excCause=12. Both steps then return to address 0.
- R11: The load routine reads memory at the ALU address (memRead=1, iorD=1), then writes register rt from memory (regWrite=1, memToReg=1, regDst=0). The store routine asserts memWrite with iorD=1 and never asserts regWrite.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| opcode | input | 6 | Opcode field of the instruction register |
| aluZero | input | 1 | ALU result is zero |
| aluOvf | input | 1 | ALU signed overflow |
| aluOp | output | 2 | ALU operation code |
| aluSelA | output | 1 | First operand select: 0 PC, 1 rs |
| aluSelB | output | 3 | Second operand select |
| pcSrc | output | 2 | PC source select |
| pcLoad | output | 1 | PC write enable (unconditional or zero-gated) |
| irWrite | output | 1 | Instruction register load |
| memRead | output | 1 | Memory read |
| memWrite | output | 1 | Memory write |
| iorD | output | 1 | Memory address: 0 PC, 1 ALU result |
| regWrite | output | 1 | Register file write |
| regDst | output | 1 | Destination: 0 rt, 1 rd |
| memToReg | output | 1 | Register write data from memory |
| targetWrite | output | 1 | Branch target register load |
| excEntry | output | 1 | Exception entry strobe |
| excCause | output | 4 | Exception cause code |
| uAddr | output | 4 | Current micro-address |

## Verification
The overflow exception is the hardest case to reach. It happens only when the overflow flag is high in the one cycle the register-type execute step is active, two cycles after fetch. The bench therefore holds each table row's flag values steady across a whole routine. With that, an overflow row reaches address 14 and a row for any other opcode shows that the flag is ignored. The zero flag is also toggled within a single branch cycle to show that pcLoad follows it combinationally. A reset applied in the middle of the load routine checks the return to fetch.

// File: rtl/ucodePkg.sv
package ucodePkg;
  localparam int UADDR_W = 4;
  localparam int OPC_W   = 6;
  localparam int CAUSE_W = 4;

  typedef enum logic [1:0] {SEQ_FETCH = 2'b00, SEQ_DISP = 2'b01, SEQ_NEXT = 2'b10, SEQ_OVCHK = 2'b11} seqT;
  typedef enum logic [1:0] {ALU_ADD = 2'b00, ALU_SUB = 2'b01, ALU_FUNC = 2'b10, ALU_OR = 2'b11} aluOpT;
  typedef enum logic [2:0] {SELB_RT = 3'b000, SELB_FOUR = 3'b001, SELB_SX = 3'b010,
                            SELB_SXSH = 3'b011, SELB_ZX = 3'b100} selBT;
  typedef enum logic [1:0] {DST_NONE = 2'b00, DST_TGT = 2'b01, DST_RD = 2'b10, DST_RT = 2'b11} dstT;
  typedef enum logic [2:0] {MEM_NONE = 3'd0, MEM_RDPC = 3'd1, MEM_RDALU = 3'd2, MEM_WRALU = 3'd3,
                            MEM_LDRT = 3'd4, MEM_EXCRI = 3'd5, MEM_EXCOV = 3'd6} memT;
  typedef enum logic [1:0] {PCW_NONE = 2'b00, PCW_ALU = 2'b01, PCW_COND = 2'b10, PCW_JUMP = 2'b11} pcCtlT;

  // 16-bit encoded microword
  typedef struct packed {
    aluOpT aluOp;
    logic  selA;
    selBT  selB;
    dstT   dest;
    memT   mem;
    logic  irWr;
    pcCtlT pcCtl;
    seqT   seq;
  } uWordT;

  // Strobes from decode to the datapath side
  typedef struct packed {
    logic [1:0]         aluOp;
    logic               aluSelA;
    logic [2:0]         aluSelB;
    logic [1:0]         pcSrc;
    logic               pcLoad;
    logic               irWrite;
    logic               memRead;
    logic               memWrite;
    logic               iorD;
    logic               regWrite;
    logic               regDst;
    logic               memToReg;
    logic               targetWrite;
    logic               excEntry;
    logic [CAUSE_W-1:0] excCause;
  } ctrlT;

  localparam logic [UADDR_W-1:0] UA_FETCH = 4'd0,  UA_DECODE = 4'd1,  UA_REXE = 4'd2,  UA_RWB  = 4'd3;
  localparam logic [UADDR_W-1:0] UA_ORI   = 4'd4,  UA_ORIWB  = 4'd5,  UA_LWA  = 4'd6,  UA_LWM  = 4'd7;
  localparam logic [UADDR_W-1:0] UA_LWWB  = 4'd8,  UA_SWA    = 4'd9,  UA_SWM  = 4'd10, UA_BEQ  = 4'd11;
  localparam logic [UADDR_W-1:0] UA_UNDEF = 4'd12, UA_JMP    = 4'd13, UA_OVF  = 4'd14;

  localparam logic [OPC_W-1:0] OP_RTYPE = 6'd0, OP_ORI = 6'd13, OP_LW = 6'd35;
  localparam logic [OPC_W-1:0] OP_SW = 6'd43, OP_BEQ = 6'd4, OP_JMP = 6'd2;

  localparam logic [CAUSE_W-1:0] CAUSE_RI = 4'd10, CAUSE_OVF = 4'd12;
endpackage

// File: rtl/ucodeStore.sv
module ucodeStore
  import ucodePkg::*;
(
  input  logic [UADDR_W-1:0] upc,
  input  logic [OPC_W-1:0]   opcode,
  output uWordT              uWord,
  output logic [UADDR_W-1:0] dispAddr
);
  localparam int STORE_DEPTH = 1 << UADDR_W;
  localparam int DISP_DEPTH  = 1 << OPC_W;

  function automatic uWordT microcode(input logic [UADDR_W-1:0] a);
    uWordT w;
    w = '{ALU_ADD, 1'b0, SELB_RT, DST_NONE, MEM_NONE, 1'b0, PCW_NONE, SEQ_FETCH};
    case (a)
      UA_FETCH:  w = '{ALU_ADD,  1'b0, SELB_FOUR, DST_NONE, MEM_RDPC,  1'b1, PCW_ALU,  SEQ_NEXT};
      UA_DECODE: w = '{ALU_ADD,  1'b0, SELB_SXSH, DST_TGT,  MEM_NONE,  1'b0, PCW_NONE, SEQ_DISP};
      UA_REXE:   w = '{ALU_FUNC, 1'b1, SELB_RT,   DST_NONE, MEM_NONE,  1'b0, PCW_NONE, SEQ_OVCHK};
      UA_RWB:    w = '{ALU_FUNC, 1'b1, SELB_RT,   DST_RD,   MEM_NONE,  1'b0, PCW_NONE, SEQ_FETCH};
      UA_ORI:    w = '{ALU_OR,   1'b1, SELB_ZX,   DST_NONE, MEM_NONE,  1'b0, PCW_NONE, SEQ_NEXT};
      UA_ORIWB:  w = '{ALU_OR,   1'b1, SELB_ZX,   DST_RT,   MEM_NONE,  1'b0, PCW_NONE, SEQ_FETCH};
      UA_LWA:    w = '{ALU_ADD,  1'b1, SELB_SX,   DST_NONE, MEM_NONE,  1'b0, PCW_NONE, SEQ_NEXT};
      UA_LWM:    w = '{ALU_ADD,  1'b1, SELB_SX,   DST_NONE, MEM_RDALU, 1'b0, PCW_NONE, SEQ_NEXT};
      UA_LWWB:   w = '{ALU_ADD,  1'b1, SELB_SX,   DST_NONE, MEM_LDRT,  1'b0, PCW_NONE, SEQ_FETCH};
      UA_SWA:    w = '{ALU_ADD,  1'b1, SELB_SX,   DST_NONE, MEM_NONE,  1'b0, PCW_NONE, SEQ_NEXT};
      UA_SWM:    w = '{ALU_ADD,  1'b1, SELB_SX,   DST_NONE, MEM_WRALU, 1'b0, PCW_NONE, SEQ_FETCH};
      UA_BEQ:    w = '{ALU_SUB,  1'b1, SELB_RT,   DST_NONE, MEM_NONE,  1'b0, PCW_COND, SEQ_FETCH};
      UA_UNDEF:  w = '{ALU_ADD,  1'b0, SELB_RT,   DST_NONE, MEM_EXCRI, 1'b0, PCW_NONE, SEQ_FETCH};
      UA_JMP:    w = '{ALU_ADD,  1'b0, SELB_RT,   DST_NONE, MEM_NONE,  1'b0, PCW_JUMP, SEQ_FETCH};
      UA_OVF:    w = '{ALU_ADD,  1'b0, SELB_RT,   DST_NONE, MEM_EXCOV, 1'b0, PCW_NONE, SEQ_FETCH};
      default:   w = '{ALU_ADD,  1'b0, SELB_RT,   DST_NONE, MEM_NONE,  1'b0, PCW_NONE, SEQ_FETCH};
    endcase
    return w;
  endfunction

  function automatic logic [UADDR_W-1:0] entryFor(input logic [OPC_W-1:0] op);
    case (op)
      OP_RTYPE: return UA_REXE;
      OP_ORI:   return UA_ORI;
      OP_LW:    return UA_LWA;
      OP_SW:    return UA_SWA;
      OP_BEQ:   return UA_BEQ;
      OP_JMP:   return UA_JMP;
      default:  return UA_UNDEF;
    endcase
  endfunction

  // Constant tables filled from the two functions
  uWordT              storeRom [STORE_DEPTH];
  logic [UADDR_W-1:0] dispRom  [DISP_DEPTH];

  for (genvar i = 0; i < STORE_DEPTH; i++) begin : gStore
    assign storeRom[i] = microcode(UADDR_W'(i));
  end
  for (genvar j = 0; j < DISP_DEPTH; j++) begin : gDisp
    assign dispRom[j] = entryFor(OPC_W'(j));
  end

  assign uWord    = storeRom[upc];
  assign dispAddr = dispRom[opcode];
endmodule

// File: rtl/ucodeSeq.sv
module ucodeSeq
  import ucodePkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  seqT                seqSel,
  input  logic [UADDR_W-1:0] dispAddr,
  input  logic               aluOvf,
  output logic [UADDR_W-1:0] upc
);
  logic [UADDR_W-1:0] nextUpc;

  always_comb begin
    case (seqSel)
      SEQ_FETCH: nextUpc = UA_FETCH;
      SEQ_DISP:  nextUpc = dispAddr;
      SEQ_NEXT:  nextUpc = upc + 1'b1;
      default:   nextUpc = aluOvf ? UA_OVF : upc + 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) upc <= UA_FETCH;
    else     upc <= nextUpc;
  end

  assert_seq_fetch_R3: assert property (@(posedge clk) disable iff (rst)
    seqSel == SEQ_FETCH |=> upc == UA_FETCH);
  assert_seq_disp_R3: assert property (@(posedge clk) disable iff (rst)
    seqSel == SEQ_DISP |=> upc == $past(dispAddr));
  assert_seq_next_R3: assert property (@(posedge clk) disable iff (rst)
    seqSel == SEQ_NEXT |=> upc == $past(upc) + 4'd1);
  assert_ovf_divert_R9: assert property (@(posedge clk) disable iff (rst)
    (seqSel == SEQ_OVCHK && aluOvf) |=> upc == UA_OVF);
endmodule

// File: rtl/ucodeDecode.sv
module ucodeDecode
  import ucodePkg::*;
(
  input  uWordT uWord,
  input  logic  aluZero,
  output ctrlT  ctl
);
  always_comb begin
    ctl             = '0;
    ctl.aluOp       = uWord.aluOp;
    ctl.aluSelA     = uWord.selA;
    ctl.aluSelB     = uWord.selB;
    ctl.irWrite     = uWord.irWr;
    case (uWord.pcCtl)
      PCW_COND: ctl.pcSrc = 2'b01;
      PCW_JUMP: ctl.pcSrc = 2'b10;
      default:  ctl.pcSrc = 2'b00;
    endcase
    ctl.pcLoad      = (uWord.pcCtl == PCW_ALU) || (uWord.pcCtl == PCW_JUMP)
                      || ((uWord.pcCtl == PCW_COND) && aluZero);
    ctl.memRead     = (uWord.mem == MEM_RDPC) || (uWord.mem == MEM_RDALU);
    ctl.memWrite    = (uWord.mem == MEM_WRALU);
    ctl.iorD        = (uWord.mem == MEM_RDALU) || (uWord.mem == MEM_WRALU);
    ctl.memToReg    = (uWord.mem == MEM_LDRT);
    ctl.regWrite    = (uWord.dest == DST_RD) || (uWord.dest == DST_RT) || (uWord.mem == MEM_LDRT);
    ctl.regDst      = (uWord.dest == DST_RD);
    ctl.targetWrite = (uWord.dest == DST_TGT);
    ctl.excEntry    = (uWord.mem == MEM_EXCRI) || (uWord.mem == MEM_EXCOV);
    if (uWord.mem == MEM_EXCRI)      ctl.excCause = CAUSE_RI;
    else if (uWord.mem == MEM_EXCOV) ctl.excCause = CAUSE_OVF;
    else                             ctl.excCause = '0;
  end
endmodule

// File: rtl/ucodeCtrl.sv
module ucodeCtrl
  import ucodePkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic [OPC_W-1:0]   opcode,
  input  logic               aluZero,
  input  logic               aluOvf,
  output logic [1:0]         aluOp,
  output logic               aluSelA,
  output logic [2:0]         aluSelB,
  output logic [1:0]         pcSrc,
  output logic               pcLoad,
  output logic               irWrite,
  output logic               memRead,
  output logic               memWrite,
  output logic               iorD,
  output logic               regWrite,
  output logic               regDst,
  output logic               memToReg,
  output logic               targetWrite,
  output logic               excEntry,
  output logic [CAUSE_W-1:0] excCause,
  output logic [UADDR_W-1:0] uAddr
);
  uWordT              uWord;
  logic [UADDR_W-1:0] dispAddr;
  logic [UADDR_W-1:0] upc;
  ctrlT               ctl;

  ucodeStore uStore (.upc(upc), .opcode(opcode), .uWord(uWord), .dispAddr(dispAddr));
  ucodeSeq   uSeq   (.clk(clk), .rst(rst), .seqSel(uWord.seq), .dispAddr(dispAddr),
                     .aluOvf(aluOvf), .upc(upc));
  ucodeDecode uDec  (.uWord(uWord), .aluZero(aluZero), .ctl(ctl));

  assign aluOp       = ctl.aluOp;
  assign aluSelA     = ctl.aluSelA;
  assign aluSelB     = ctl.aluSelB;
  assign pcSrc       = ctl.pcSrc;
  assign pcLoad      = ctl.pcLoad;
  assign irWrite     = ctl.irWrite;
  assign memRead     = ctl.memRead;
  assign memWrite    = ctl.memWrite;
  assign iorD        = ctl.iorD;
  assign regWrite    = ctl.regWrite;
  assign regDst      = ctl.regDst;
  assign memToReg    = ctl.memToReg;
  assign targetWrite = ctl.targetWrite;
  assign excEntry    = ctl.excEntry;
  assign excCause    = ctl.excCause;
  assign uAddr       = upc;

  assert_fetch_word_R2: assert property (@(posedge clk) disable iff (rst)
    upc == UA_FETCH |-> (irWrite && memRead && !iorD && pcLoad && pcSrc == 2'b00 && aluSelB == 3'b001));
  assert_fetch_to_decode_R2: assert property (@(posedge clk) disable iff (rst)
    upc == UA_FETCH |=> upc == UA_DECODE);
  assert_cond_pc_R8: assert property (@(posedge clk) disable iff (rst)
    upc == UA_BEQ |-> pcLoad == aluZero);
  assert_no_ovf_wb_R9: assert property (@(posedge clk) disable iff (rst)
    (upc == UA_REXE && aluOvf) |=> !regWrite);
  assert_exc_return_R10: assert property (@(posedge clk) disable iff (rst)
    excEntry |=> upc == UA_FETCH);
  assert_store_no_wr_R11: assert property (@(posedge clk) disable iff (rst)
    memWrite |-> !regWrite);
endmodule

// File: tb/sim_ucodeCtrl.sv
`timescale 1ns/1ps
module sim_ucodeCtrl;
  logic clk = 1'b0;
  logic rst;
  logic [5:0] opcode;
  logic aluZero, aluOvf;
  logic [1:0] aluOp, pcSrc;
  logic aluSelA, pcLoad, irWrite, memRead, memWrite, iorD;
  logic regWrite, regDst, memToReg, targetWrite, excEntry;
  logic [2:0] aluSelB;
  logic [3:0] excCause, uAddr;

  int nChecks = 0;
  int nFails  = 0;

  always #10 clk = ~clk;

  ucodeCtrl u0 (.clk(clk), .rst(rst), .opcode(opcode), .aluZero(aluZero), .aluOvf(aluOvf),
    .aluOp(aluOp), .aluSelA(aluSelA), .aluSelB(aluSelB), .pcSrc(pcSrc), .pcLoad(pcLoad),
    .irWrite(irWrite), .memRead(memRead), .memWrite(memWrite), .iorD(iorD),
    .regWrite(regWrite), .regDst(regDst), .memToReg(memToReg), .targetWrite(targetWrite),
    .excEntry(excEntry), .excCause(excCause), .uAddr(uAddr));

  // {op6, zero, ovf, entry4, len3, regWr, memWr, pcLd, exc, cause4, aluOp2, selB3, pcSrc2}
  localparam int NV = 11;
  localparam logic [29:0] VECS [NV] = '{
    {6'd0,  1'b0, 1'b0, 4'd2,  3'd2, 1'b1, 1'b0, 1'b0, 1'b0, 4'd0,  2'b10, 3'b000, 2'b00},
    {6'd0,  1'b0, 1'b1, 4'd2,  3'd2, 1'b0, 1'b0, 1'b0, 1'b1, 4'd12, 2'b10, 3'b000, 2'b00},
    {6'd13, 1'b0, 1'b0, 4'd4,  3'd2, 1'b1, 1'b0, 1'b0, 1'b0, 4'd0,  2'b11, 3'b100, 2'b00},
    {6'd13, 1'b0, 1'b1, 4'd4,  3'd2, 1'b1, 1'b0, 1'b0, 1'b0, 4'd0,  2'b11, 3'b100, 2'b00},
    {6'd35, 1'b0, 1'b0, 4'd6,  3'd3, 1'b1, 1'b0, 1'b0, 1'b0, 4'd0,  2'b00, 3'b010, 2'b00},
    {6'd43, 1'b0, 1'b0, 4'd9,  3'd2, 1'b0, 1'b1, 1'b0, 1'b0, 4'd0,  2'b00, 3'b010, 2'b00},
    {6'd4,  1'b1, 1'b0, 4'd11, 3'd1, 1'b0, 1'b0, 1'b1, 1'b0, 4'd0,  2'b01, 3'b000, 2'b01},
    {6'd4,  1'b0, 1'b0, 4'd11, 3'd1, 1'b0, 1'b0, 1'b0, 1'b0, 4'd0,  2'b01, 3'b000, 2'b01},
    {6'd2,  1'b0, 1'b0, 4'd13, 3'd1, 1'b0, 1'b0, 1'b1, 1'b0, 4'd0,  2'b00, 3'b000, 2'b10},
    {6'd63, 1'b0, 1'b0, 4'd12, 3'd1, 1'b0, 1'b0, 1'b0, 1'b1, 4'd10, 2'b00, 3'b000, 2'b00},
    {6'd1,  1'b0, 1'b0, 4'd12, 3'd1, 1'b0, 1'b0, 1'b0, 1'b1, 4'd10, 2'b00, 3'b000, 2'b00}
  };

  task automatic chkEq(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic chkFetch(input string tag);
    chkEq({tag, " R2 uAddr"}, uAddr, 0);
    chkEq({tag, " R2 fetch word"},
          {aluOp, aluSelA, aluSelB, memRead, iorD, irWrite, pcLoad, pcSrc},
          {2'b00, 1'b0, 3'b001, 1'b1, 1'b0, 1'b1, 1'b1, 2'b00});
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    rst = 1'b1; opcode = '0; aluZero = 1'b0; aluOvf = 1'b0;
    repeat (3) @(negedge clk);
    chkEq("R1 reset address", uAddr, 0);
    chkFetch("R1 reset");
    rst = 1'b0;

    // table walk: one routine per row, starting at a negedge with uAddr 0
    for (int v = 0; v < NV; v++) begin
      logic [29:0] row;
      int len;
      bit sawRw, sawMw, sawPl, sawExc;
      int cause;
      row = VECS[v];
      opcode = row[29:24]; aluZero = row[23]; aluOvf = row[22];
      #1;
      chkFetch($sformatf("row%0d", v));
      @(negedge clk);
      chkEq($sformatf("row%0d R3 decode addr", v), uAddr, 1);
      chkEq($sformatf("row%0d R6 decode selB", v), aluSelB, 3'b011);
      @(negedge clk);
      chkEq($sformatf("row%0d R4 entry", v), uAddr, row[21:18]);
      chkEq($sformatf("row%0d R5 aluOp", v), aluOp, row[6:5]);
      chkEq($sformatf("row%0d R6 selB", v), aluSelB, row[4:2]);
      chkEq($sformatf("row%0d R7 pcSrc", v), pcSrc, row[1:0]);
      len = 0; sawRw = 0; sawMw = 0; sawPl = 0; sawExc = 0; cause = 0;
      while (uAddr != 0 && len < 8) begin
        if (regWrite) sawRw = 1;
        if (memWrite) sawMw = 1;
        if (pcLoad)   sawPl = 1;
        if (excEntry) begin sawExc = 1; cause = excCause; end
        len++;
        @(negedge clk);
      end
      chkEq($sformatf("row%0d R4 routine length", v), len, row[17:15]);
      chkEq($sformatf("row%0d R9 R11 regWrite", v), sawRw, row[14]);
      chkEq($sformatf("row%0d R11 memWrite", v), sawMw, row[13]);
      chkEq($sformatf("row%0d R8 pcLoad", v), sawPl, row[12]);
      chkEq($sformatf("row%0d R10 excEntry", v), sawExc, row[11]);
      chkEq($sformatf("row%0d R10 excCause", v), cause, row[10:7]);
    end

    // R9 write-back controls, R11 load/store strobes
    opcode = 6'd0; aluOvf = 1'b0;
    repeat (3) @(negedge clk);
    chkEq("R9 wb addr", uAddr, 3);
    chkEq("R9 wb regWrite/regDst", {regWrite, regDst}, 2'b11);
    @(negedge clk);
    opcode = 6'd35;
    repeat (3) @(negedge clk);
    chkEq("R11 load mem addr", uAddr, 7);
    chkEq("R11 load read", {memRead, iorD, regWrite}, 3'b110);
    @(negedge clk);
    chkEq("R11 load wb", {regWrite, memToReg, regDst}, 3'b110);
    @(negedge clk);
    opcode = 6'd43;
    repeat (3) @(negedge clk);
    chkEq("R11 store", {memWrite, iorD, regWrite}, 3'b110);
    @(negedge clk);

    // R8: pcLoad follows zero within the branch step
    opcode = 6'd4; aluZero = 1'b0;
    repeat (2) @(negedge clk);
    chkEq("R8 branch addr", uAddr, 11);
    #1 chkEq("R8 zero low", pcLoad, 0);
    aluZero = 1'b1;
    #1 chkEq("R8 zero high", pcLoad, 1);
    @(negedge clk);
    aluZero = 1'b0;

    // R1: reset in the middle of the load routine
    opcode = 6'd35;
    repeat (3) @(negedge clk);
    chkEq("R1 mid-routine addr", uAddr, 7);
    rst = 1'b1;
    @(negedge clk);
    chkEq("R1 reset mid-routine", uAddr, 0);
    chkFetch("R1 after reset");
    rst = 1'b0;
    @(negedge clk);
    chkEq("R1 resume decode", uAddr, 1);

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule